// File: doc/BRIEF.md
# Serial-Command to APB Bridge

This block sits behind the command decoder of a frame-based serial control bus. Commands whose address lies in the upper range (0x1000 and above) become APB transactions. One APB access can take longer than one bus frame, so the bridge answers every bridged command one cycle after it arrives. It then runs the APB transfer in the background. The answer is COMMAND_OK when the bridge was idle and COMMAND_FAIL when an earlier transfer is still running. A failed command is dropped. A bridged address that has no register behind it still gets COMMAND_OK.

The bridge also owns six byte-wide registers at 0x0F00 to 0x0F05, reached through the same command port:

| Offset | Name | Access | Contents |
|---|---|---|---|
| 0x0F00 | status | read; bit 1 write-one-to-clear | bit 0 busy, bit 1 timeout error |
| 0x0F01 | last read address, low byte | read-only | |
| 0x0F02 | last read address, high byte | read-only | |
| 0x0F03 | readback | read-only | read data of the last read |
| 0x0F04 | timeout control | read/write | bits [3:0] extension n, bit 7 no-limit |
| 0x0F05 | interrupt mask | read/write | bit 0 |

An APB transfer whose slave does not assert PREADY in time is abandoned. The abandoned transfer raises the error flag, and the error flag drives the interrupt line when it is unmasked. Writes through the bridge finish when the slave finishes, not on a frame edge.

Internally the block is a three-state machine:
- IDLE: no transfer.
- SETUP: PSEL high, PENABLE low, for one cycle.
- ACCESS: PSEL and PENABLE high.

It has four transitions:
- start: IDLE to SETUP, when a bridged command is accepted.
- enter: SETUP to ACCESS, always.
- complete: ACCESS to IDLE, on PREADY.
- expire: ACCESS to IDLE, when the timeout limit is reached.

Top module: `scb_apb_bridge`

## Requirements
- R1: A command with address at or above 0x1000 that arrives while the bridge is idle is answered in the next cycle with rsp_valid=1 and rsp_ok=1. In that same next cycle the APB setup phase begins with paddr, pwrite and pwdata taken from the command.
- R2: A bridged command that arrives while a transfer is outstanding is answered in the next cycle with rsp_valid=1 and rsp_ok=0. It starts no APB transfer and changes no bridge register.
- R3: A command below 0x1000 never starts an APB transfer. Addresses 0x0F00 to 0x0F05 are answered with rsp_ok=1 from the bridge registers; a write gives rsp_rdata=0. Any other low address gets no response.
- R4: Status bit 0 (busy) reads 1 from the cycle after a bridged command is accepted until the transfer completes or is abandoned.
- R5: Registers 0x0F01 (low byte) and 0x0F02 (high byte) hold the address of the most recently accepted bridged read. Writes to them have no effect.
- R6: Register 0x0F03 holds the PRDATA of the most recently completed bridged read.
- R7: With timeout control at 0, the slave may hold PREADY low for at most 7 access cycles. On the 8th access cycle without PREADY, the transfer is abandoned at the next edge. Abandoning sets status bit 1, and for a read it sets 0x0F03 to 0.
- R8: With timeout control bits [3:0] = n, the limit becomes 8*(n+1) access cycles.
- R9: With timeout control bit 7 set, no transfer is ever abandoned.
- R10: Writing 1 to status bit 1 clears the error flag. If a timeout falls in the same cycle as that write, the flag stays set.
- R11: The interrupt mask at 0x0F05 bit 0 resets to 1. irq is high exactly while the error flag is set and the mask is 0.
- R12: APB framing holds: the setup cycle is always followed by an access cycle. While PREADY is low in an access cycle, paddr and pwrite stay stable.
- R13: After reset there is no transfer or response, irq is 0, status and timeout control read 0, and the mask reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Command address |
| cmd_wdata | input | 8 | Command write data |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | 1 = COMMAND_OK, 0 = COMMAND_FAIL |
| rsp_rdata | output | 8 | Bridge register read data |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction |
| paddr | output | 16 | APB address |
| pwdata | output | 8 | APB write data |
| prdata | input | 8 | APB read data |
| pready | input | 1 | APB ready |
| irq | output | 1 | Timeout error interrupt |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a transfer ending and a new bridged command arriving. The busy test uses the state from before the edge, so that command must be refused. The bench provokes this by sending a second bridged command during a long wait. Its reference model then judges the response against the busy state it holds for that cycle.

The second pair is a timeout setting the error flag while the host writes 1 to clear it. The bench times the clear write to land exactly on the expiry edge. It then expects status bit 1 still to read 1, because a set wins over a clear.

// File: rtl/scb_apb_pkg.sv
package scb_apb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } apb_state_e;

    typedef enum logic [1:0] {
        CMD_BRIDGED = 2'd0,
        CMD_OWN     = 2'd1,
        CMD_OTHER   = 2'd2
    } cmd_class_e;

    localparam int CSR_COUNT  = 6;
    localparam int OFS_STATUS = 0;
    localparam int OFS_LRD_LO = 1;
    localparam int OFS_LRD_HI = 2;
    localparam int OFS_RDBK   = 3;
    localparam int OFS_TMO    = 4;
    localparam int OFS_MASK   = 5;

    localparam int BIT_BUSY   = 0;
    localparam int BIT_ERR    = 1;

endpackage

// File: rtl/scb_cmd_decode.sv
module scb_cmd_decode
    import scb_apb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BRIDGE_LO = 'h1000,
    parameter int CSR_BASE  = 'h0F00,
    parameter int OFS_W     = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output cmd_class_e        cls,
    output logic [OFS_W-1:0]  ofs
);
    localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(BRIDGE_LO);
    localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CSR_BASE);
    localparam logic [ADDR_W-1:0] CSR_E = ADDR_W'(CSR_BASE + CSR_COUNT);

    logic [ADDR_W-1:0] delta;

    always_comb begin
        delta = addr - CSR_A;
        ofs   = delta[OFS_W-1:0];
        if (addr >= LO_A) begin
            cls = CMD_BRIDGED;
        end else if (addr >= CSR_A && addr < CSR_E) begin
            cls = CMD_OWN;
        end else begin
            cls = CMD_OTHER;
        end
    end
endmodule

// File: rtl/scb_apb_fsm.sv
module scb_apb_fsm
    import scb_apb_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int TMO_BASE = 8,
    parameter int EXT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              st_write,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_wdata,
    input  logic [EXT_W-1:0]  tmo_ext,
    input  logic              tmo_dis,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pready,
    output logic              busy,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              tmo_evt,
    output logic              tmo_rd
);
    localparam int MAX_LIM = TMO_BASE * (2 ** EXT_W);
    localparam int CNT_W   = $clog2(MAX_LIM + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    apb_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  limit;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    logic              expire;

    assign limit  = CNT_W'(TMO_BASE) * (CNT_W'(tmo_ext) + CNT_W'(1));
    assign expire = (state_q == ST_ACCESS) && !pready && !tmo_dis && (cnt_q >= limit);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, enter, complete, expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ACCESS;
            ST_ACCESS: if (pready || expire) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Captured command and access-cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                addr_q  <= st_addr;
                wdata_q <= st_wdata;
                write_q <= st_write;
            end
            if (state_q == ST_SETUP) begin
                cnt_q <= CNT_W'(1);
            end else if (state_q == ST_ACCESS && !pready && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        psel    = (state_q != ST_IDLE);
        penable = (state_q == ST_ACCESS);
        pwrite  = write_q;
        paddr   = addr_q;
        pwdata  = wdata_q;
        busy    = (state_q != ST_IDLE);
        rd_done = (state_q == ST_ACCESS) && pready && !write_q;
        rd_data = prdata;
        tmo_evt = expire;
        tmo_rd  = !write_q;
    end
endmodule

// File: rtl/scb_bridge_regs.sv
module scb_bridge_regs
    import scb_apb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int EXT_W  = 4,
    parameter int OFS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  cmd_class_e        cls,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              tmo_evt,
    input  logic              tmo_rd,
    output logic              start,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [EXT_W-1:0]  tmo_ext,
    output logic              tmo_dis,
    output logic              err_flag,
    output logic              irq_mask,
    output logic              irq
);
    logic [ADDR_W-1:0] lrd_q;
    logic [DATA_W-1:0] rdbk_q;
    logic [DATA_W-1:0] rd_mux;
    logic              own_wr;
    logic              own_rd;
    logic              clr_err;

    assign start   = cmd_valid && (cls == CMD_BRIDGED) && !busy;
    assign own_wr  = cmd_valid && (cls == CMD_OWN) && cmd_write;
    assign own_rd  = cmd_valid && (cls == CMD_OWN) && !cmd_write;
    assign clr_err = own_wr && (int'(ofs) == OFS_STATUS) && cmd_wdata[BIT_ERR];

    always_comb begin
        rd_mux = '0;
        unique case (int'(ofs))
            OFS_STATUS: begin
                rd_mux[BIT_BUSY] = busy;
                rd_mux[BIT_ERR]  = err_flag;
            end
            OFS_LRD_LO: rd_mux = lrd_q[DATA_W-1:0];
            OFS_LRD_HI: rd_mux = DATA_W'(lrd_q >> DATA_W);
            OFS_RDBK:   rd_mux = rdbk_q;
            OFS_TMO: begin
                rd_mux[EXT_W-1:0]  = tmo_ext;
                rd_mux[DATA_W-1]   = tmo_dis;
            end
            OFS_MASK:   rd_mux[0] = irq_mask;
            default:    rd_mux = '0;
        endcase
    end

    // Response path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cmd_valid && (cls != CMD_OTHER);
            rsp_ok    <= (cls == CMD_OWN) || !busy;
            rsp_rdata <= own_rd ? rd_mux : '0;
        end
    end

    // Bridge registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lrd_q    <= '0;
            rdbk_q   <= '0;
            tmo_ext  <= '0;
            tmo_dis  <= 1'b0;
            err_flag <= 1'b0;
            irq_mask <= 1'b1;
        end else begin
            if (start && !cmd_write) begin
                lrd_q <= cmd_addr;
            end
            if (rd_done) begin
                rdbk_q <= rd_data;
            end else if (tmo_evt && tmo_rd) begin
                rdbk_q <= '0;
            end
            if (tmo_evt) begin
                err_flag <= 1'b1;
            end else if (clr_err) begin
                err_flag <= 1'b0;
            end
            if (own_wr && int'(ofs) == OFS_TMO) begin
                tmo_ext <= cmd_wdata[EXT_W-1:0];
                tmo_dis <= cmd_wdata[DATA_W-1];
            end
            if (own_wr && int'(ofs) == OFS_MASK) begin
                irq_mask <= cmd_wdata[0];
            end
        end
    end

    assign irq = err_flag && !irq_mask;
endmodule

// File: rtl/scb_apb_bridge.sv
module scb_apb_bridge
    import scb_apb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int BRIDGE_LO = 'h1000,
    parameter int CSR_BASE  = 'h0F00,
    parameter int TMO_BASE  = 8,
    parameter int EXT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pready,
    output logic              irq
);
    localparam int OFS_W = $clog2(CSR_COUNT);

    cmd_class_e        cls;
    logic [OFS_W-1:0]  ofs;
    logic              start;
    logic              busy;
    logic              rd_done;
    logic [DATA_W-1:0] rd_data;
    logic              tmo_evt;
    logic              tmo_rd;
    logic [EXT_W-1:0]  tmo_ext;
    logic              tmo_dis;
    logic              err_flag;
    logic              irq_mask;

    scb_cmd_decode #(
        .ADDR_W(ADDR_W), .BRIDGE_LO(BRIDGE_LO), .CSR_BASE(CSR_BASE), .OFS_W(OFS_W)
    ) u_dec (
        .addr(cmd_addr), .cls(cls), .ofs(ofs)
    );

    scb_apb_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_BASE(TMO_BASE), .EXT_W(EXT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .st_write(cmd_write),
        .st_addr(cmd_addr), .st_wdata(cmd_wdata), .tmo_ext(tmo_ext), .tmo_dis(tmo_dis),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .busy(busy), .rd_done(rd_done),
        .rd_data(rd_data), .tmo_evt(tmo_evt), .tmo_rd(tmo_rd)
    );

    scb_bridge_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_W(EXT_W), .OFS_W(OFS_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cls(cls), .ofs(ofs),
        .busy(busy), .rd_done(rd_done), .rd_data(rd_data), .tmo_evt(tmo_evt),
        .tmo_rd(tmo_rd), .start(start), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_rdata(rsp_rdata), .tmo_ext(tmo_ext), .tmo_dis(tmo_dis),
        .err_flag(err_flag), .irq_mask(irq_mask), .irq(irq)
    );
endmodule

// File: rtl/scb_apb_bridge_chk.sv
module scb_apb_bridge_chk #(
    parameter int ADDR_W    = 16,
    parameter int BRIDGE_LO = 'h1000,
    parameter int TMO_BASE  = 8,
    parameter int EXT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              pready,
    input logic [EXT_W-1:0]  tmo_ext,
    input logic              tmo_dis,
    input logic              err_flag
);
    localparam int CNT_W = $clog2(TMO_BASE * (2 ** EXT_W) + 1) + 1;
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BRIDGE_LO);

    logic [CNT_W-1:0] acc_wait;
    logic [CNT_W-1:0] lim;
    logic             bridged;

    assign lim     = CNT_W'(TMO_BASE) * (CNT_W'(tmo_ext) + CNT_W'(1));
    assign bridged = cmd_valid && (cmd_addr >= LO_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_wait <= '0;
        end else if (psel && penable && !pready) begin
            if (acc_wait != '1) acc_wait <= acc_wait + CNT_W'(1);
        end else begin
            acc_wait <= '0;
        end
    end

    assert_accept_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bridged && !psel |=> psel && !penable && rsp_valid && rsp_ok && paddr == $past(cmd_addr));

    assert_fail_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bridged && psel |=> rsp_valid && !rsp_ok);

    assert_local_no_apb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_addr < LO_A && !psel |=> !psel);

    assert_setup_then_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !penable |=> psel && penable);

    assert_stable_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && !pready |=> !psel || ($stable(paddr) && $stable(pwrite)));

    assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable |-> tmo_dis || acc_wait < lim);

    assert_abandon_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && !pready |=> psel || err_flag);

    assert_err_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(psel && penable && !pready));
endmodule

bind scb_apb_bridge scb_apb_bridge_chk #(
    .ADDR_W(ADDR_W), .BRIDGE_LO(BRIDGE_LO), .TMO_BASE(TMO_BASE), .EXT_W(EXT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pready(pready), .tmo_ext(tmo_ext),
    .tmo_dis(tmo_dis), .err_flag(err_flag)
);

// File: tb/test_scb_apb_bridge.sv
module test_scb_apb_bridge;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid, cmd_write;
    logic [15:0] cmd_addr;
    logic [7:0] cmd_wdata;
    logic       rsp_valid, rsp_ok;
    logic [7:0] rsp_rdata;
    logic       psel, penable, pwrite;
    logic [15:0] paddr;
    logic [7:0] pwdata, prdata;
    logic       pready, irq;

    int n_checks = 0;
    int n_fail   = 0;
    int slv_wait = 0;
    logic [7:0] slv_data = 8'h00;
    int acc_k = 0;

    always #2 clk = ~clk;

    scb_apb_bridge i_scb_apb_bridge (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .irq(irq)
    );

    // APB slave with a programmable number of wait cycles
    assign pready = psel && penable && (acc_k == slv_wait);
    assign prdata = slv_data;
    always @(posedge clk) begin
        if (psel && penable && !pready) acc_k <= acc_k + 1;
        else acc_k <= 0;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, compared on every falling edge
    int   m_ph, m_wc, m_ext;
    bit   m_err, m_mask, m_dis, m_wr;
    logic [15:0] m_lrd, m_addr;
    logic [7:0]  m_rb, m_wd;
    bit   e_rv, e_ok;
    logic [7:0]  e_rd;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_wc = 0; m_ext = 0; m_err = 0; m_mask = 1; m_dis = 0; m_wr = 0;
            m_lrd = 0; m_addr = 0; m_rb = 0; m_wd = 0; e_rv = 0; e_ok = 0; e_rd = 0;
        end else begin
            bit busy_old, tmo, clr;
            check(psel == (m_ph != 0), "R4 psel/busy", psel, m_ph != 0);
            check(penable == (m_ph == 2), "R12 penable", penable, m_ph == 2);
            if (m_ph != 0)
                check(paddr == m_addr && pwrite == m_wr && (m_wr == 0 || pwdata == m_wd),
                      "R1 apb fields", paddr, m_addr);
            check(irq == (m_err && !m_mask), "R11 irq", irq, m_err && !m_mask);
            check(rsp_valid == e_rv, "R3 rsp_valid", rsp_valid, e_rv);
            if (e_rv) begin
                check(rsp_ok == e_ok, "R2 rsp_ok", rsp_ok, e_ok);
                check(rsp_rdata == e_rd, "R6 rsp_rdata", rsp_rdata, e_rd);
            end
            busy_old = (m_ph != 0);
            tmo = 0; clr = 0;
            e_rv = 0; e_ok = 0; e_rd = 0;
            // APB progress from the old state
            if (m_ph == 1) begin
                m_ph = 2; m_wc = 1;
            end else if (m_ph == 2) begin
                if (pready) begin
                    if (!m_wr) m_rb = slv_data;
                    m_ph = 0;
                end else if (!m_dis && m_wc >= 8 * (m_ext + 1)) begin
                    tmo = 1;
                    if (!m_wr) m_rb = 0;
                    m_ph = 0;
                end else begin
                    m_wc++;
                end
            end
            // Command handling from the old register values
            if (cmd_valid) begin
                if (cmd_addr >= 16'h1000) begin
                    e_rv = 1; e_ok = !busy_old;
                    if (!busy_old) begin
                        m_ph = 1; m_addr = cmd_addr; m_wr = cmd_write; m_wd = cmd_wdata;
                        if (!cmd_write) m_lrd = cmd_addr;
                    end
                end else if (cmd_addr >= 16'h0F00 && cmd_addr <= 16'h0F05) begin
                    e_rv = 1; e_ok = 1;
                    if (!cmd_write) begin
                        case (cmd_addr[2:0])
                            3'd0: e_rd = {6'b0, m_err, busy_old};
                            3'd1: e_rd = m_lrd[7:0];
                            3'd2: e_rd = m_lrd[15:8];
                            3'd3: e_rd = m_rb;
                            3'd4: e_rd = {m_dis, 3'b0, 4'(m_ext)};
                            default: e_rd = {7'b0, m_mask};
                        endcase
                    end else begin
                        case (cmd_addr[2:0])
                            3'd0: clr = cmd_wdata[1];
                            3'd4: begin m_ext = int'(cmd_wdata[3:0]); m_dis = cmd_wdata[7]; end
                            3'd5: m_mask = cmd_wdata[0];
                            default: ;
                        endcase
                    end
                end
            end
            if (clr) m_err = 0;
            if (tmo) m_err = 1;
        end
    end

    task automatic send(input bit w, input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [7:0] v);
        send(1'b0, a, 8'h00);
        v = rsp_rdata;
    endtask

    task automatic wait_idle();
        do begin
            @(posedge clk); #1;
        end while (psel);
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_test();
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        check(!psel && !rsp_valid && !irq, "R13 reset outputs", {psel, rsp_valid, irq}, 0);
        rst_n = 1'b1;

        rd_reg(16'h0F00, v); check(v == 8'h00, "R13 status", v, 0);
        rd_reg(16'h0F05, v); check(v == 8'h01, "R13 R11 mask reset", v, 1);
        rd_reg(16'h0F04, v); check(v == 8'h00, "R13 timeout ctrl", v, 0);

        // R1: idle write accepted
        slv_wait = 0;
        send(1'b1, 16'h1234, 8'h5A);
        check(rsp_valid && rsp_ok, "R1 ok response", rsp_ok, 1);
        wait_idle();

        // R4 R5 R6: read with two wait cycles
        slv_wait = 2; slv_data = 8'hA5;
        send(1'b0, 16'h4321, 8'h00);
        rd_reg(16'h0F00, v); check(v[0] == 1'b1, "R4 busy bit", v, 1);
        wait_idle();
        rd_reg(16'h0F03, v); check(v == 8'hA5, "R6 readback", v, 8'hA5);
        rd_reg(16'h0F01, v); check(v == 8'h21, "R5 last addr low", v, 8'h21);
        send(1'b1, 16'h0F02, 8'hFF);
        rd_reg(16'h0F02, v); check(v == 8'h43, "R5 last addr high", v, 8'h43);

        // R2: command while busy is refused and discarded
        slv_wait = 5; slv_data = 8'h3C;
        send(1'b0, 16'h2000, 8'h00);
        send(1'b0, 16'h3456, 8'h00);
        check(rsp_valid && !rsp_ok, "R2 fail response", rsp_ok, 0);
        wait_idle();
        rd_reg(16'h0F02, v); check(v == 8'h20, "R2 discarded read", v, 8'h20);

        // R3: local address outside the window
        send(1'b1, 16'h0100, 8'hFF);
        check(!rsp_valid && !psel, "R3 no response", {rsp_valid, psel}, 0);

        // R7: boundary, 7 waits completes
        slv_wait = 7; slv_data = 8'h77;
        send(1'b0, 16'h5000, 8'h00);
        wait_idle();
        rd_reg(16'h0F00, v); check(v[1] == 1'b0, "R7 seven waits ok", v, 0);
        rd_reg(16'h0F03, v); check(v == 8'h77, "R7 R6 readback", v, 8'h77);

        // R7: 8 waits abandoned
        slv_wait = 8;
        send(1'b0, 16'h5001, 8'h00);
        wait_idle();
        rd_reg(16'h0F00, v); check(v[1] == 1'b1, "R7 error set", v, 2);
        rd_reg(16'h0F03, v); check(v == 8'h00, "R7 readback zero", v, 0);
        check(!irq, "R11 masked", irq, 0);
        send(1'b1, 16'h0F05, 8'h00);
        check(irq, "R11 unmasked", irq, 1);
        send(1'b1, 16'h0F00, 8'h02);
        check(!irq, "R10 cleared irq", irq, 0);
        rd_reg(16'h0F00, v); check(v[1] == 1'b0, "R10 cleared", v, 0);

        // R8: extended limit 16
        send(1'b1, 16'h0F04, 8'h01);
        slv_wait = 15;
        send(1'b1, 16'h6000, 8'h99);
        wait_idle();
        rd_reg(16'h0F00, v); check(v[1] == 1'b0, "R8 fifteen waits ok", v, 0);
        slv_wait = 16;
        send(1'b1, 16'h6001, 8'h98);
        wait_idle();
        rd_reg(16'h0F00, v); check(v[1] == 1'b1, "R8 sixteen waits expire", v, 2);
        send(1'b1, 16'h0F00, 8'h02);

        // R9: no limit
        send(1'b1, 16'h0F04, 8'h80);
        slv_wait = 40; slv_data = 8'hC3;
        send(1'b0, 16'h7000, 8'h00);
        wait_idle();
        rd_reg(16'h0F00, v); check(v[1] == 1'b0, "R9 no timeout", v, 0);
        rd_reg(16'h0F03, v); check(v == 8'hC3, "R9 readback", v, 8'hC3);

        // R10: clear lands on the expiry edge, set wins
        send(1'b1, 16'h0F04, 8'h00);
        slv_wait = 20;
        send(1'b0, 16'h7100, 8'h00);
        repeat (7) @(posedge clk);
        send(1'b1, 16'h0F00, 8'h02);
        check(!psel, "R10 expired", psel, 0);
        rd_reg(16'h0F00, v); check(v[1] == 1'b1, "R10 set wins", v, 2);

        repeat (4) @(posedge clk);
        finish_test();
    end
endmodule